// File: doc/BRIEF.md
# Change-of-State Digital I/O Controller

This block is a register-mapped digital I/O port for a large chip. It drives 24 general outputs and reads 24 general inputs. It also has one 8-bit bank of TTL pins, which software can turn between input and output. Sixteen byte-wide registers hold the whole state. A simple synchronous bus reaches them with 32-bit words, so four register bytes share each word and each byte has its own enable. Reads return data one cycle after the strobe.

All 32 input-capable bits are watched for transitions. These are the 24 general inputs plus the TTL bank. Each 8-bit bank can be armed for rising edges, falling edges or both. A detected edge sets a sticky status bit, and software clears it by writing a one to it. One level interrupt line stays high while any status bit is set. A write to the top register byte returns every software-visible register to its reset value.

Top module: `cos_dio_ctrl`

## Requirements
- R1: Register bytes 0, 1 and 2 (word 0, lanes 0..2) hold output bits 7:0, 15:8 and 23:16. They drive `out_pins` directly. Each lane is written only when its byte enable is set, and a read returns the last value written.
- R2: Register bytes 4..7 (word 1) read the synchronized general inputs in bits 23:0 and the synchronized TTL pins in bits 31:24. Writes to word 1 change nothing.
- R3: Bit 1 of register byte 12 (word 3, lane 0) is the TTL direction. When it is 1, `ttl_oe` is high, and `ttl_out` always carries the TTL latch (register byte 3). When it is 0, `ttl_oe` is low. The other bits of byte 12 read as zero.
- R4: Register byte 14 (word 3, lane 2) arms detection. Bits 0..3 arm rising edges for banks 0..3, and bits 4..7 arm falling edges for the same banks. Bank 3 is the TTL bank. An edge in a bank that is not armed for that direction sets nothing.
- R5: A status bit sets when an armed edge appears on its input and stays set. Writing a 1 to its position in word 2 clears it. Writing a 0 leaves it unchanged.
- R6: If a clearing write and a new armed edge reach the same status bit in the same cycle, the bit stays set.
- R7: Word 2 holds all 32 status bits. General inputs 0..23 are in bits 23:0 and the TTL pins are in bits 31:24. One full-width write of ones clears them all.
- R8: `irq` is high exactly while at least one status bit is set. Bit 0 of register byte 15 (word 3, bit 24) reads that same level.
- R9: Any write that enables lane 3 of word 3 clears the outputs, the TTL latch, the direction bit, the edge arming and all status bits. The effect is visible after that clock edge.
- R10: Register byte 13 (word 3, lane 1) reads zero, and writes to it are ignored.
- R11: Read data appears on `rd_data` after the clock edge that samples the read strobe. It holds until the next read. A pin change is synchronized through two flops, so its status bit sets on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address; bits 3:2 select the word |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while any status bit is set |
| out_pins | output | 24 | General output drive |
| in_pins | input | 24 | General input pads (asynchronous) |
| ttl_in | input | 8 | TTL pad input (asynchronous) |
| ttl_out | output | 8 | TTL output data |
| ttl_oe | output | 1 | TTL output enable |

## Verification
The bench times a clearing write to land in the same cycle as a new edge on that bit. A design that let the clear win would lose that event, and the status would read zero. Pin changes are made in several banks at once, with only some directions armed. A design with the arming bits swapped, or with bank lanes crossed, would set the wrong status bits or put the TTL bit in the wrong byte. The bench also writes zeros to the status word and writes to the input and reserved bytes. A design that cleared on zero, or decoded those bytes as writable, would change state that is read back right afterward. The soft reset is issued while outputs, direction and status are all non-zero. The interrupt latency is sampled one edge before and on the edge where the status should set.

// File: rtl/cos_dio_pkg.sv
// Shared constants for the change-of-state I/O controller.
// Assumes a 4-word map of 4 byte lanes each.
package cos_dio_pkg;
    localparam int BYTE_W    = 8;
    localparam int LANES     = 4;
    localparam int DATA_W    = LANES * BYTE_W;
    localparam int ADDR_W    = 4;
    localparam int OUT_BANKS = 3;
    localparam int IN_BANKS  = 3;

    // word index = byte address / LANES
    typedef enum logic [1:0] {
        WORD_OUT = 2'd0,
        WORD_IN  = 2'd1,
        WORD_COS = 2'd2,
        WORD_CTL = 2'd3
    } word_e;

    localparam int LANE_DIR   = 0;   // direction byte
    localparam int LANE_RSV   = 1;   // reserved byte
    localparam int LANE_ARM   = 2;   // edge arming byte
    localparam int LANE_RST   = 3;   // irq status / soft reset byte
    localparam int DIR_BIT    = 1;   // TTL output mode bit
endpackage

// File: rtl/cos_dio_sync.sv
// Two-flop synchronizer plus one history stage.
// Assumes d is asynchronous to clk; cur and prev are both synchronized.
module cos_dio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Purpose: move pins into clk domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;
endmodule

// File: rtl/cos_dio_status.sv
// Sticky change-of-state status, one bank of BANK_W bits per arming pair.
// Assumes cur/prev are synchronized samples one cycle apart. A new edge
// wins over a same-cycle clear; soft_clr wins over everything.
module cos_dio_status #(
    parameter int BANK_W = 8,
    parameter int BANKS  = 4,
    localparam int W     = BANK_W * BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cur,
    input  logic [W-1:0]     prev,
    input  logic [BANKS-1:0] rise_arm,
    input  logic [BANKS-1:0] fall_arm,
    input  logic [W-1:0]     clr,
    input  logic             soft_clr,
    output logic [W-1:0]     status
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] c_b, p_b, hit_b, st_q;

        assign c_b   = cur [b*BANK_W +: BANK_W];
        assign p_b   = prev[b*BANK_W +: BANK_W];
        assign hit_b = ({BANK_W{rise_arm[b]}} & c_b & ~p_b)
                     | ({BANK_W{fall_arm[b]}} & ~c_b & p_b);

        // Purpose: hold each bank's status until cleared by ones.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                st_q <= '0;
            end else begin
                st_q <= (st_q & ~clr[b*BANK_W +: BANK_W]) | hit_b;
            end
        end

        assign status[b*BANK_W +: BANK_W] = st_q;
    end
endmodule

// File: rtl/cos_dio_regs.sv
// Writable configuration: output bytes, TTL latch, direction bit, arming.
// Assumes word 0 has OUT_BANKS output lanes followed by the TTL latch lane.
module cos_dio_regs
    import cos_dio_pkg::*;
#(
    parameter int NOUT  = OUT_BANKS,
    parameter int BW    = BYTE_W,
    parameter int NLANE = LANES,
    localparam int DW   = NLANE * BW,
    localparam int OW   = NOUT * BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_out,
    input  logic             wr_ctl,
    input  logic [NLANE-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic             soft_clr,
    output logic [OW-1:0]    out_q,
    output logic [BW-1:0]    ttl_q,
    output logic             dir_q,
    output logic [BW-1:0]    arm_q
);
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        if (l < NOUT) begin : g_out
            // Purpose: one output byte, written by its own lane enable.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) out_q[l*BW +: BW] <= '0;
                else if (wr_out && be[l]) out_q[l*BW +: BW] <= wdata[l*BW +: BW];
            end
        end else if (l == NOUT) begin : g_ttl
            // Purpose: TTL output latch in the lane after the outputs.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) ttl_q <= '0;
                else if (wr_out && be[l]) ttl_q <= wdata[l*BW +: BW];
            end
        end
    end

    // Purpose: direction bit and edge arming byte in the control word.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            dir_q <= 1'b0;
            arm_q <= '0;
        end else if (wr_ctl) begin
            if (be[LANE_DIR]) dir_q <= wdata[LANE_DIR*BW + DIR_BIT];
            if (be[LANE_ARM]) arm_q <= wdata[LANE_ARM*BW +: BW];
        end
    end
endmodule

// File: rtl/cos_dio_ctrl.sv
// Top of the change-of-state I/O controller: bus decode, read mux, irq.
// Assumes one access per req_valid cycle, word selected by req_addr[3:2].
module cos_dio_ctrl
    import cos_dio_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int NLANE = LANES,
    parameter int AW    = ADDR_W,
    parameter int NOUT  = OUT_BANKS,
    parameter int NIN   = IN_BANKS,
    localparam int DW   = NLANE * BW,
    localparam int OW   = NOUT * BW,
    localparam int IW   = NIN * BW,
    localparam int NCOS = NIN + 1,
    localparam int CW   = NCOS * BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [NLANE-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rd_data,
    output logic             irq,
    output logic [OW-1:0]    out_pins,
    input  logic [IW-1:0]    in_pins,
    input  logic [BW-1:0]    ttl_in,
    output logic [BW-1:0]    ttl_out,
    output logic             ttl_oe
);
    word_e           word;
    logic            wr, rd, soft_clr;
    logic [DW-1:0]   be_mask;
    logic [CW-1:0]   clr_mask;
    logic [CW-1:0]   s_cur, s_prev, cos_status;
    logic [OW-1:0]   out_q;
    logic [BW-1:0]   ttl_q, arm_q;
    logic            dir_q;

    assign word     = word_e'(req_addr[AW-1:AW-2]);
    assign wr       = req_valid &&  req_write;
    assign rd       = req_valid && !req_write;
    assign soft_clr = wr && (word == WORD_CTL) && req_be[LANE_RST];

    for (genvar l = 0; l < NLANE; l++) begin : g_mask
        assign be_mask[l*BW +: BW] = {BW{req_be[l]}};
    end

    assign clr_mask = (wr && word == WORD_COS) ? CW'(req_wdata & be_mask) : '0;

    cos_dio_sync #(.W(CW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ttl_in, in_pins}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    cos_dio_status #(.BANK_W(BW), .BANKS(NCOS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (s_cur),
        .prev    (s_prev),
        .rise_arm(arm_q[NCOS-1:0]),
        .fall_arm(arm_q[2*NCOS-1:NCOS]),
        .clr     (clr_mask),
        .soft_clr(soft_clr),
        .status  (cos_status)
    );

    cos_dio_regs #(.NOUT(NOUT), .BW(BW), .NLANE(NLANE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_out  (wr && word == WORD_OUT),
        .wr_ctl  (wr && word == WORD_CTL),
        .be      (req_be),
        .wdata   (req_wdata),
        .soft_clr(soft_clr),
        .out_q   (out_q),
        .ttl_q   (ttl_q),
        .dir_q   (dir_q),
        .arm_q   (arm_q)
    );

    assign irq      = |cos_status;
    assign out_pins = out_q;
    assign ttl_out  = ttl_q;
    assign ttl_oe   = dir_q;

    // Purpose: registered read mux, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd) begin
            unique case (word)
                WORD_OUT: rd_data <= DW'({ttl_q, out_q});
                WORD_IN:  rd_data <= DW'(s_cur);
                WORD_COS: rd_data <= DW'(cos_status);
                default: begin
                    rd_data                          <= '0;
                    rd_data[LANE_DIR*BW + DIR_BIT]   <= dir_q;
                    rd_data[LANE_ARM*BW +: BW]       <= arm_q;
                    rd_data[LANE_RST*BW]             <= irq;
                end
            endcase
        end
    end
endmodule

// File: rtl/cos_dio_checker.sv
// Temporal checks on the controller, attached by bind below.
module cos_dio_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [3:0]  req_addr,
    input logic [3:0]  req_be,
    input logic [31:0] req_wdata,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic [23:0] out_pins,
    input logic [7:0]  ttl_out,
    input logic        ttl_oe,
    input logic [31:0] status
);
    logic wr_cos, wr_in, wr_ctl, rst_wr;
    assign wr_cos = req_valid && req_write && req_addr[3:2] == 2'd2;
    assign wr_in  = req_valid && req_write && req_addr[3:2] == 2'd1;
    assign wr_ctl = req_valid && req_write && req_addr[3:2] == 2'd3;
    assign rst_wr = wr_ctl && req_be[3];

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cos && !rst_wr) |=> ((status & $past(status)) == $past(status))); // R5

    AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && req_be[0] && !req_be[3]) |=> (ttl_oe == $past(req_wdata[1]))); // R3

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (out_pins == '0 && ttl_out == '0 && !ttl_oe && !irq)); // R9

    AST_INPUT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |=> ($stable(out_pins) && $stable(ttl_out) && $stable(ttl_oe))); // R2

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rd_data)); // R11
endmodule

bind cos_dio_ctrl cos_dio_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_be   (req_be),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .irq      (irq),
    .out_pins (out_pins),
    .ttl_out  (ttl_out),
    .ttl_oe   (ttl_oe),
    .status   (cos_status)
);

// File: tb/cos_dio_ctrl_test.sv
module cos_dio_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0, req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq, ttl_oe;
    logic [23:0] out_pins, in_pins = '0;
    logic [7:0]  ttl_in = '0, ttl_out;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cos_dio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_data(rd_data), .irq(irq), .out_pins(out_pins), .in_pins(in_pins),
        .ttl_in(ttl_in), .ttl_out(ttl_out), .ttl_oe(ttl_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic wr_word(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = {w, 2'b00}; req_be = be; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0; req_be = '0;
    endtask

    task automatic rd_word(input logic [1:0] w, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = {w, 2'b00};
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R9 reset out", {8'h0, out_pins}, 32'h0);
        chk("R3 reset oe", {31'h0, ttl_oe}, 32'h0);
        chk("R8 reset irq", {31'h0, irq}, 32'h0);
        rd_word(2'd0, d); chk("R1 reset word0", d, 32'h0);
    endtask

    task automatic t_outputs;
        logic [31:0] d;
        wr_word(2'd0, 4'b0111, 32'hA5C33C5A);
        chk("R1 full write", {8'h0, out_pins}, 32'h00C33C5A);
        rd_word(2'd0, d); chk("R1 readback", d, 32'h00C33C5A);
        wr_word(2'd0, 4'b0010, 32'h1111FF11);
        chk("R1 lane write", {8'h0, out_pins}, 32'h00C3FF5A);
        wr_word(2'd0, 4'b1000, 32'h81000000);
        chk("R3 latch data", {24'h0, ttl_out}, 32'h81);
        chk("R3 oe still low", {31'h0, ttl_oe}, 32'h0);
        rd_word(2'd0, d); chk("R1 word0 with latch", d, 32'h81C3FF5A);
    endtask

    task automatic t_dir;
        logic [31:0] d;
        wr_word(2'd3, 4'b0001, 32'h000000FF);
        chk("R3 output mode", {31'h0, ttl_oe}, 32'h1);
        rd_word(2'd3, d); chk("R3 dir readback", d, 32'h00000002);
        wr_word(2'd3, 4'b0001, 32'h000000FD);
        chk("R3 input mode", {31'h0, ttl_oe}, 32'h0);
    endtask

    task automatic t_inputs;
        logic [31:0] d;
        in_pins = 24'h123456; ttl_in = 8'h9A;
        idle(4);
        rd_word(2'd1, d); chk("R2 input read", d, 32'h9A123456);
        wr_word(2'd1, 4'b1111, 32'hFFFFFFFF);
        chk("R2 write ignored out", {8'h0, out_pins}, 32'h00C3FF5A);
        rd_word(2'd1, d); chk("R2 input unchanged", d, 32'h9A123456);
        chk("R4 no arm no irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr_word(2'd3, 4'b0010, 32'h0000FF00);
        rd_word(2'd3, d); chk("R10 reserved zero", d, 32'h0);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        wr_word(2'd3, 4'b0100, 32'h00010000);            // bank0 rising only
        in_pins = 24'h12FF55;                            // bit0 up, bit1 down, bank1 up
        idle(4);
        rd_word(2'd2, d); chk("R4 rising only bank0", d, 32'h00000001);
        wr_word(2'd2, 4'b1111, 32'h0);
        rd_word(2'd2, d); chk("R5 write zero keeps", d, 32'h00000001);
        wr_word(2'd2, 4'b1111, 32'h1);
        rd_word(2'd2, d); chk("R5 write one clears", d, 32'h0);
        chk("R8 irq low after clear", {31'h0, irq}, 32'h0);
        wr_word(2'd3, 4'b0100, 32'h00100000);            // bank0 falling only
        in_pins = 24'h12FF54;
        idle(4);
        rd_word(2'd2, d); chk("R4 falling bank0", d, 32'h00000001);
        chk("R8 irq high", {31'h0, irq}, 32'h1);
        rd_word(2'd3, d); chk("R8 irq bit in word3", d, 32'h01100000);
        wr_word(2'd2, 4'b0001, 32'h000000FF);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        wr_word(2'd3, 4'b0100, 32'h00FF0000);
        in_pins = 24'h13FF55; ttl_in = 8'h1A;
        idle(4);
        rd_word(2'd2, d); chk("R7 bank lanes", d, 32'h80010001);
        wr_word(2'd2, 4'b1111, 32'hFFFFFFFF);
        rd_word(2'd2, d); chk("R7 wide clear", d, 32'h0);
    endtask

    task automatic t_latency;
        in_pins = 24'h13FE55;                            // bit8 falls
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R11 not set after two edges", {31'h0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 set on third edge", {31'h0, irq}, 32'h1);
        wr_word(2'd2, 4'b1111, 32'hFFFFFFFF);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        in_pins = 24'h13FE54;                            // bit0 falls
        idle(4);
        in_pins = 24'h13FE55;                            // bit0 rises
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr_word(2'd2, 4'b0001, 32'h00000001);           // clear on the set edge
        rd_word(2'd2, d); chk("R6 edge beats clear", d, 32'h00000001);
        wr_word(2'd2, 4'b0001, 32'h00000001);
        rd_word(2'd2, d); chk("R6 later clear works", d, 32'h0);
    endtask

    task automatic t_soft;
        logic [31:0] d;
        wr_word(2'd3, 4'b0001, 32'h2);
        in_pins = 24'h13FE54;
        idle(4);
        chk("R9 precondition irq", {31'h0, irq}, 32'h1);
        wr_word(2'd3, 4'b1000, 32'h0);
        chk("R9 outputs cleared", {8'h0, out_pins}, 32'h0);
        chk("R9 latch and oe cleared", {23'h0, ttl_oe, ttl_out}, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        rd_word(2'd3, d); chk("R9 control cleared", d, 32'h0);
        rd_word(2'd2, d); chk("R9 status cleared", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_outputs();
        t_dir();
        t_inputs();
        t_reserved();
        t_edges();
        t_wide();
        t_latency();
        t_collision();
        t_soft();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule